// File: doc/BRIEF.md
# Effective Address Generation Unit

This block turns the addressing fields of an already decoded instruction into either a finished effective address or the operand value itself. The caller presents a 3-bit mode code, a register-number field, a 16-bit immediate/address/offset field and the current program counter, then pulses `start`. The unit picks a register through its own read port into the register file, does the arithmetic the mode calls for and returns a value together with a flag that says whether the value is an operand or an address.

Seven of the eight modes finish in one calculation, and the answer is ready on the cycle after `start`. The memory-indirect mode needs the word stored at the address in the instruction. The block raises a read request, holds the address steady until memory acknowledges, and then returns the fetched word as the effective address. While it waits it reports busy and ignores any new `start`.

Top module: `ea_gen_unit`

## Requirements
- R1: Mode 0 (implicit register) drives `rf_raddr` to register 0 whatever `reg_sel` holds, and returns that register's contents with `is_operand` = 1.
- R2: Mode 1 (explicit register) reads the register named by `reg_sel` and returns its contents with `is_operand` = 1.
- R3: Mode 2 (immediate) returns `field` unchanged with `is_operand` = 1.
- R4: Mode 3 (direct) returns `field` unchanged as an address, with `is_operand` = 0.
- R5: Mode 4 (register indirect) returns the contents of the register named by `reg_sel` as an address, with `is_operand` = 0.
- R6: Mode 5 (indexed) returns the register named by `reg_sel` plus `field[7:0]` sign-extended to 16 bits, modulo 2^16, with `is_operand` = 0. `field[15:8]` has no effect.
- R7: Mode 6 (PC-relative) returns `pc` plus `field[7:0]` sign-extended to 16 bits, modulo 2^16, with `is_operand` = 0.
- R8: Mode 7 (memory indirect) raises `mem_req` with `mem_addr` = `field` on the cycle after `start`. Both are held until a cycle in which `mem_ack` is high. On the next cycle `done` is high, `mem_req` is low, `result` equals the `mem_rdata` sampled with the ack, and `is_operand` = 0.
- R9: For modes 0 to 6, `done` is high for exactly the one cycle after `start`, and no memory request is made.
- R10: While `busy` is high (a memory-indirect request is waiting), a `start` is ignored. It changes neither `mem_addr` nor `result`, and it produces no `done`.
- R11: Reset (synchronous, active high) leaves `done`, `mem_req` and `busy` low, and it abandons a pending request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin resolving the presented instruction fields |
| mode | input | 3 | Addressing mode code, 0 to 7 |
| reg_sel | input | 4 | Register-number field |
| field | input | 16 | Immediate, address or offset field |
| pc | input | 16 | Current program counter |
| rf_raddr | output | 4 | Register file read index |
| rf_rdata | input | 16 | Register file read data (combinational) |
| mem_req | output | 1 | Data memory read request |
| mem_addr | output | 16 | Data memory read address |
| mem_ack | input | 1 | Memory acknowledge, data valid |
| mem_rdata | input | 16 | Word returned by memory |
| done | output | 1 | Result valid pulse |
| result | output | 16 | Effective address or operand |
| is_operand | output | 1 | 1 when `result` is an operand, 0 when it is an address |
| busy | output | 1 | Waiting for a memory acknowledge |

## Verification
A one-step result is due on the first cycle after `start`. The bench drives inputs on the falling edge and looks for `done` on the next falling edge, so exactly one rising edge lies between stimulus and sample. For the indirect mode, the request must be visible on the falling edge after `start`, and the fetched word must appear with `done` on the falling edge after the one where `mem_ack` was driven. Between those two points each waiting cycle is checked to confirm the request is still held. A scoreboard queue pairs every `done` with the value the driver predicted when it issued the request. Any `done` without a matching entry, or an entry left over at the end, is reported as a failure.

// File: rtl/eag_pkg.sv
package eag_pkg;

    localparam int ADDR_W   = 16;
    localparam int OFF_W    = 8;
    localparam int NUM_REGS = 16;
    localparam int RIDX_W   = $clog2(NUM_REGS);
    localparam int MODE_W   = 3;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [RIDX_W-1:0] ridx_t;

    typedef enum logic [MODE_W-1:0] {
        AM_IMPL_REG = 3'd0,
        AM_EXPL_REG = 3'd1,
        AM_IMM      = 3'd2,
        AM_DIRECT   = 3'd3,
        AM_REG_IND  = 3'd4,
        AM_INDEXED  = 3'd5,
        AM_PC_REL   = 3'd6,
        AM_MEM_IND  = 3'd7
    } amode_e;

    typedef struct packed {
        addr_t value;
        logic  is_operand;
    } eag_result_t;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_WAIT = 1'b1
    } seq_state_e;

    // Sign-extend the low OFF_W bits of an instruction field
    function automatic addr_t sext_off(input addr_t f);
        return {{(ADDR_W-OFF_W){f[OFF_W-1]}}, f[OFF_W-1:0]};
    endfunction

    function automatic logic needs_mem(input amode_e m);
        return (m == AM_MEM_IND);
    endfunction

endpackage

// File: rtl/eag_regsel.sv
module eag_regsel
    import eag_pkg::*;
#(
    parameter int ACC_IDX = 0
) (
    input  amode_e mode,
    input  ridx_t  reg_sel,
    output ridx_t  rf_raddr
);
    localparam ridx_t ACC = ridx_t'(ACC_IDX);

    always_comb begin
        if (mode == AM_IMPL_REG) begin
            rf_raddr = ACC;
        end else begin
            rf_raddr = reg_sel;
        end
    end
endmodule

// File: rtl/eag_calc.sv
module eag_calc
    import eag_pkg::*;
(
    input  amode_e      mode,
    input  addr_t       field,
    input  addr_t       pc,
    input  addr_t       rf_rdata,
    output eag_result_t res
);
    addr_t off;

    always_comb begin
        off = sext_off(field);
        case (mode)
            AM_IMPL_REG, AM_EXPL_REG: res = '{value: rf_rdata,       is_operand: 1'b1};
            AM_IMM:                   res = '{value: field,          is_operand: 1'b1};
            AM_DIRECT:                res = '{value: field,          is_operand: 1'b0};
            AM_REG_IND:               res = '{value: rf_rdata,       is_operand: 1'b0};
            AM_INDEXED:               res = '{value: rf_rdata + off, is_operand: 1'b0};
            AM_PC_REL:                res = '{value: pc + off,       is_operand: 1'b0};
            default:                  res = '{value: field,          is_operand: 1'b0};
        endcase
    end
endmodule

// File: rtl/eag_seq.sv
module eag_seq
    import eag_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  amode_e      mode,
    input  addr_t       field,
    input  eag_result_t calc_res,
    input  logic        mem_ack,
    input  addr_t       mem_rdata,
    output logic        mem_req,
    output addr_t       mem_addr,
    output logic        done,
    output eag_result_t res_q,
    output logic        busy
);
    seq_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            mem_req  <= 1'b0;
            mem_addr <= '0;
            done     <= 1'b0;
            res_q    <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (start) begin
                        if (needs_mem(mode)) begin
                            mem_req  <= 1'b1;
                            mem_addr <= field;
                            state    <= SQ_WAIT;
                        end else begin
                            res_q <= calc_res;
                            done  <= 1'b1;
                        end
                    end
                end
                SQ_WAIT: begin
                    if (mem_ack) begin
                        mem_req <= 1'b0;
                        res_q   <= '{value: mem_rdata, is_operand: 1'b0};
                        done    <= 1'b1;
                        state   <= SQ_IDLE;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign busy = (state == SQ_WAIT);
endmodule

// File: rtl/ea_gen_unit.sv
module ea_gen_unit
    import eag_pkg::*;
#(
    parameter int ACC_IDX = 0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [MODE_W-1:0]   mode,
    input  logic [RIDX_W-1:0]   reg_sel,
    input  logic [ADDR_W-1:0]   field,
    input  logic [ADDR_W-1:0]   pc,
    output logic [RIDX_W-1:0]   rf_raddr,
    input  logic [ADDR_W-1:0]   rf_rdata,
    output logic                mem_req,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic                mem_ack,
    input  logic [ADDR_W-1:0]   mem_rdata,
    output logic                done,
    output logic [ADDR_W-1:0]   result,
    output logic                is_operand,
    output logic                busy
);
    amode_e      mode_e;
    eag_result_t calc_res;
    eag_result_t res_q;

    assign mode_e = amode_e'(mode);

    eag_regsel #(.ACC_IDX(ACC_IDX)) u_regsel (
        .mode     (mode_e),
        .reg_sel  (reg_sel),
        .rf_raddr (rf_raddr)
    );

    eag_calc u_calc (
        .mode     (mode_e),
        .field    (field),
        .pc       (pc),
        .rf_rdata (rf_rdata),
        .res      (calc_res)
    );

    eag_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .mode      (mode_e),
        .field     (field),
        .calc_res  (calc_res),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .done      (done),
        .res_q     (res_q),
        .busy      (busy)
    );

    assign result     = res_q.value;
    assign is_operand = res_q.is_operand;
endmodule

// File: rtl/eag_chk.sv
module eag_chk
    import eag_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [MODE_W-1:0] mode,
    input logic [ADDR_W-1:0] field,
    input logic              busy,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_rdata,
    input logic              done,
    input logic [ADDR_W-1:0] result,
    input logic              is_operand
);
    // R9
    one_step_done_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && mode != 3'd7) |=> (done && !mem_req));

    // R8
    req_issue_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && mode == 3'd7) |=> (mem_req && !done && mem_addr == $past(field)));

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R8
    ack_done_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack) |=> (done && !mem_req && !is_operand && result == $past(mem_rdata)));

    // R3
    imm_value_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && mode == 3'd2) |=> (result == $past(field) && is_operand));

    // R4
    direct_value_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && mode == 3'd3) |=> (result == $past(field) && !is_operand));

    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !mem_ack) |=> (!done && $stable(result)));

    // R11
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!done && !mem_req && !busy));
endmodule

bind ea_gen_unit eag_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .mode       (mode),
    .field      (field),
    .busy       (busy),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .done       (done),
    .result     (result),
    .is_operand (is_operand)
);

// File: tb/ea_gen_unit_test.sv
module ea_gen_unit_test;
    import eag_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  mode = '0;
    logic [3:0]  reg_sel = '0;
    logic [15:0] field = '0;
    logic [15:0] pc = '0;
    logic [3:0]  rf_raddr;
    logic [15:0] rf_rdata;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        done;
    logic [15:0] result;
    logic        is_operand;
    logic        busy;

    logic [15:0] rf [16];
    assign rf_rdata = rf[rf_raddr];

    always #10 clk = ~clk;

    ea_gen_unit uut (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .reg_sel(reg_sel),
        .field(field), .pc(pc), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .done(done), .result(result),
        .is_operand(is_operand), .busy(busy)
    );

    typedef struct {
        logic [15:0] val;
        logic        op;
        string       req;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   errors = 0;
    bit   finished = 0;

    task automatic check(input bit ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] sx(input logic [15:0] f);
        return f[7] ? {8'hFF, f[7:0]} : {8'h00, f[7:0]};
    endfunction

    // Monitor: every done pops the oldest prediction
    always @(negedge clk) begin
        if (!rst && done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R10 unexpected done", result, 16'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(result == e.val && is_operand == e.op, e.req,
                      {result[14:0], is_operand}, {e.val[14:0], e.op});
            end
        end
    end

    task automatic one_step(input logic [2:0] m, input logic [3:0] rs,
                            input logic [15:0] f, input logic [15:0] ev,
                            input logic eo, input string req);
        exp_t e;
        @(negedge clk);
        start = 1'b1; mode = m; reg_sel = rs; field = f;
        e.val = ev; e.op = eo; e.req = req;
        sb.push_back(e);
        @(negedge clk);
        start = 1'b0;
        check(done && !mem_req, "R9 done one cycle after start", {14'b0, done, mem_req}, 16'h2);
    endtask

    task automatic indirect(input logic [15:0] f, input logic [15:0] rd,
                            input int waits, input bit inject);
        exp_t e;
        @(negedge clk);
        start = 1'b1; mode = 3'd7; field = f;
        e.val = rd; e.op = 1'b0; e.req = "R8 indirect result";
        sb.push_back(e);
        @(negedge clk);
        start = 1'b0;
        check(mem_req && mem_addr == f && !done, "R8 request issued", mem_addr, f);
        check(busy, "R10 busy while waiting", {15'b0, busy}, 16'h1);
        for (int i = 0; i < waits; i++) begin
            if (inject && i == 0) begin
                start = 1'b1; mode = 3'd2; field = ~f;
            end
            @(negedge clk);
            start = 1'b0;
            check(mem_req && mem_addr == f && !done, "R10 request held, start ignored", mem_addr, f);
        end
        mem_ack = 1'b1; mem_rdata = rd;
        @(negedge clk);
        mem_ack = 1'b0; mem_rdata = 16'hDEAD;
        check(done && !mem_req, "R8 done after ack, request dropped", {14'b0, done, mem_req}, 16'h2);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) rf[i] = 16'h1000 + 16'(i) * 16'h0111;
        rf[0]  = 16'hA5C3;
        rf[15] = 16'hFFF0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check(!done && !mem_req && !busy, "R11 reset state", {13'b0, done, mem_req, busy}, 16'h0);

        one_step(3'd0, 4'd5, 16'h1234, rf[0], 1'b1, "R1 implicit register");
        one_step(3'd1, 4'd5, 16'h1234, rf[5], 1'b1, "R2 explicit register r5");
        one_step(3'd1, 4'd14, 16'h0000, rf[14], 1'b1, "R2 explicit register r14");
        one_step(3'd2, 4'd3, 16'h00AB, 16'h00AB, 1'b1, "R3 immediate");
        one_step(3'd3, 4'd3, 16'h4321, 16'h4321, 1'b0, "R4 direct");
        one_step(3'd4, 4'd3, 16'h9999, rf[3], 1'b0, "R5 register indirect");
        one_step(3'd5, 4'd2, 16'h0010, rf[2] + 16'h0010, 1'b0, "R6 indexed positive");
        one_step(3'd5, 4'd2, 16'h00F0, rf[2] - 16'h0010, 1'b0, "R6 indexed negative");
        one_step(3'd5, 4'd15, 16'h0020, 16'h0010, 1'b0, "R6 indexed wrap");
        one_step(3'd5, 4'd2, 16'h5504, rf[2] + sx(16'h5504), 1'b0, "R6 upper field ignored");
        pc = 16'h0100;
        one_step(3'd6, 4'd0, 16'h0080, 16'h0080, 1'b0, "R7 pc relative negative");
        one_step(3'd6, 4'd0, 16'h007F, 16'h017F, 1'b0, "R7 pc relative positive");
        pc = 16'hFFFE;
        one_step(3'd6, 4'd0, 16'h0004, 16'h0002, 1'b0, "R7 pc relative wrap");

        indirect(16'h2468, 16'hBEEF, 0, 1'b0);
        indirect(16'h1357, 16'h0C0D, 3, 1'b1);
        one_step(3'd3, 4'd0, 16'h7777, 16'h7777, 1'b0, "R4 direct after indirect");

        // R11 reset abandons a pending request
        @(negedge clk);
        start = 1'b1; mode = 3'd7; field = 16'h3333;
        @(negedge clk);
        start = 1'b0;
        check(mem_req, "R11 request pending before reset", {15'b0, mem_req}, 16'h1);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(!mem_req && !busy && !done, "R11 reset clears request", {13'b0, done, mem_req, busy}, 16'h0);
        repeat (2) @(negedge clk);
        check(!done, "R11 no done after reset", {15'b0, done}, 16'h0);

        repeat (2) @(negedge clk);
        check(sb.size() == 0, "R9 every result delivered", 16'(sb.size()), 16'h0);
        finished = 1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            finish_run();
        end
    end
endmodule